// File: doc/BRIEF.md
# Dual-Issue Operand-Ready Scoreboard

This block sits between the decode stage of a two-wide in-order front end and its execution pipes: simple integer, complex integer (multiply and divide), load/store, and floating point. Each cycle up to two candidate instructions arrive, one per slot. Each candidate carries a destination register, up to two source registers and a latency class. Each register operand carries a flag that selects the integer or floating-point file and an enable bit. The block returns a per-slot ready. An instruction issues in a cycle where its valid and ready are both high.

Issuing marks the destination busy with a down-counter loaded from a per-class latency table. Bypass paths for both files make a result usable in the cycle it is produced, so a dependent instruction issued L cycles after its producer is granted. Integer and floating-point divides are not pipelined. While one runs, it locks out further work on its unit.

Handshake and back-pressure rules: slot 0 ready depends only on scoreboard state and slot 0 fields, never on slot 0 valid. Slot 1 ready additionally requires slot 0 to be valid and ready in the same cycle. A slot whose ready is low keeps its instruction, and the front end presents it again later. Nothing is recorded for a slot unless valid and ready are both high.

Top module: `dual_issue_scoreboard`

## Requirements
- R1: After reset every register in both files is free and both divide units are idle, so an instruction with any operands is granted.
- R2: A register written by an issued instruction of latency L in cycle t is busy for that file: a slot naming it as an enabled source is denied in cycles t+1 to t+L-1 and granted from cycle t+L.
- R3: Class codes and latencies: 0 simple integer = 1, 1 multiply = 3, 2 integer divide = 33, 3 integer load = 3, 4 floating-point load = 4, 5 floating-point arithmetic or move = 5, 6 floating-point divide = 30, 7 condition-register update = 2.
- R4: The integer and floating-point files are tracked independently. Register N busy in one file never blocks register N in the other, and this holds within a slot pair as well.
- R5: A slot whose enabled destination is still busy is denied until that register is free.
- R6: After an integer divide issues in cycle t, classes 1 and 2 are denied in both slots until cycle t+33. After a floating-point divide issues in cycle t, classes 5, 6 and 7 are denied until cycle t+30.
- R7: Slot 1 is denied if an enabled source of slot 1 names the enabled destination of slot 0 (same file and index), or if both enabled destinations are the same register.
- R8: Slot 1 is denied when both slots need the same single unit. The single units are multiply/divide (classes 1, 2), load/store (3, 4) and floating point (5, 6, 7). Class 0 may pair with anything.
- R9: Issue is in order: slot 1 is ready only when slot 0 is valid and ready in the same cycle.
- R10: A source or destination whose enable bit is low has no effect on either slot's ready.
- R11: A slot presented with valid low records nothing: no register becomes busy and no unit is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Per-slot instruction valid |
| in_ready | output | 2 | Per-slot issue grant |
| in_class | input | 2x3 | Per-slot latency class code |
| in_dst | input | 2xREG_W | Per-slot destination register index |
| in_dst_fp | input | 2 | Destination is in the floating-point file |
| in_dst_en | input | 2 | Destination is written |
| in_src | input | 2x2xREG_W | Per-slot, per-operand source register index |
| in_src_fp | input | 2x2 | Source is in the floating-point file |
| in_src_en | input | 2x2 | Source is read |

## Verification
A wrong counter or lock value inside the block is invisible until a later instruction names the affected register or unit. It then shows as a ready that rises one or more cycles early or late, or never. The bench therefore sweeps every latency class with a reader presented on every cycle after its producer, so any off-by-one in the countdown appears on the exact cycle it occurs. Pairing, ordering and file-separation faults show in the same cycle as a wrong slot 1 ready. A long stretch of mixed traffic on a small register window keeps hazards dense, so a leaked busy state surfaces within a few dozen cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int SLOTS = 2;

  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_MUL  = 3'd1,
    CLS_IDIV = 3'd2,
    CLS_LD   = 3'd3,
    CLS_FLD  = 3'd4,
    CLS_FOP  = 3'd5,
    CLS_FDIV = 3'd6,
    CLS_CR   = 3'd7
  } lat_class_e;

  typedef enum logic [1:0] {
    UNIT_DUP = 2'd0,
    UNIT_MDV = 2'd1,
    UNIT_LSU = 2'd2,
    UNIT_FPU = 2'd3
  } unit_e;

  function automatic unit_e unit_of(input lat_class_e c);
    case (c)
      CLS_MUL, CLS_IDIV:         return UNIT_MDV;
      CLS_LD, CLS_FLD:           return UNIT_LSU;
      CLS_FOP, CLS_FDIV, CLS_CR: return UNIT_FPU;
      default:                   return UNIT_DUP;
    endcase
  endfunction

endpackage

// File: rtl/sb_cnt_bank.sv
module sb_cnt_bank
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int CNT_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            wr_en,
  input  logic [SLOTS-1:0][REG_W-1:0] wr_idx,
  input  logic [SLOTS-1:0][CNT_W-1:0] wr_val,
  output logic [NUM_REGS-1:0]         busy
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (wr_en[0] && wr_idx[0] == REG_W'(r)) begin
        cnt <= wr_val[0];
      end else if (wr_en[1] && wr_idx[1] == REG_W'(r)) begin
        cnt <= wr_val[1];
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign busy[r] = (cnt != '0);
  end

endmodule

// File: rtl/sb_unit_lock.sv
module sb_unit_lock #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  output logic             locked
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= start_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign locked = (remain != '0);

endmodule

// File: rtl/sb_slot_check.sv
module sb_slot_check
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int NUM_SRC  = 2
) (
  input  logic [NUM_REGS-1:0]          busy_int,
  input  logic [NUM_REGS-1:0]          busy_fp,
  input  logic                         mdv_locked,
  input  logic                         fpu_locked,
  input  logic [2:0]                   cls,
  input  logic [REG_W-1:0]             dst,
  input  logic                         dst_fp,
  input  logic                         dst_en,
  input  logic [NUM_SRC-1:0][REG_W-1:0] src,
  input  logic [NUM_SRC-1:0]           src_fp,
  input  logic [NUM_SRC-1:0]           src_en,
  output logic                         ok
);

  logic [NUM_SRC-1:0] src_hit;
  logic               dst_hit;
  logic               unit_hit;

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      src_hit[k] = src_en[k] && (src_fp[k] ? busy_fp[src[k]] : busy_int[src[k]]);
    end
    dst_hit = dst_en && (dst_fp ? busy_fp[dst] : busy_int[dst]);
    case (unit_of(lat_class_e'(cls)))
      UNIT_MDV: unit_hit = mdv_locked;
      UNIT_FPU: unit_hit = fpu_locked;
      default:  unit_hit = 1'b0;
    endcase
    ok = !(|src_hit) && !dst_hit && !unit_hit;
  end

endmodule

// File: rtl/sb_pair_check.sv
module sb_pair_check
  import sb_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [2:0]                    old_cls,
  input  logic [REG_W-1:0]              old_dst,
  input  logic                          old_dst_fp,
  input  logic                          old_dst_en,
  input  logic [2:0]                    yng_cls,
  input  logic [REG_W-1:0]              yng_dst,
  input  logic                          yng_dst_fp,
  input  logic                          yng_dst_en,
  input  logic [NUM_SRC-1:0][REG_W-1:0] yng_src,
  input  logic [NUM_SRC-1:0]            yng_src_fp,
  input  logic [NUM_SRC-1:0]            yng_src_en,
  output logic                          ok
);

  logic  raw;
  logic  waw;
  logic  clash;
  unit_e u_old;
  unit_e u_yng;

  always_comb begin
    raw = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (yng_src_en[k] && old_dst_en && yng_src_fp[k] == old_dst_fp &&
          yng_src[k] == old_dst) begin
        raw = 1'b1;
      end
    end
    waw   = old_dst_en && yng_dst_en && old_dst_fp == yng_dst_fp && old_dst == yng_dst;
    u_old = unit_of(lat_class_e'(old_cls));
    u_yng = unit_of(lat_class_e'(yng_cls));
    clash = (u_old == u_yng) && (u_old != UNIT_DUP);
    ok    = !raw && !waw && !clash;
  end

endmodule

// File: rtl/dual_issue_scoreboard.sv
module dual_issue_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int NUM_SRC  = 2,
  parameter int LAT_ALU  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_IDIV = 33,
  parameter int LAT_LD   = 3,
  parameter int LAT_FLD  = 4,
  parameter int LAT_FOP  = 5,
  parameter int LAT_FDIV = 30,
  parameter int LAT_CR   = 2,
  localparam int REG_W   = (NUM_REGS < 2) ? 1 : $clog2(NUM_REGS)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             in_valid,
  output logic [1:0]                             in_ready,
  input  logic [1:0][2:0]                        in_class,
  input  logic [1:0][REG_W-1:0]                  in_dst,
  input  logic [1:0]                             in_dst_fp,
  input  logic [1:0]                             in_dst_en,
  input  logic [1:0][NUM_SRC-1:0][REG_W-1:0]     in_src,
  input  logic [1:0][NUM_SRC-1:0]                in_src_fp,
  input  logic [1:0][NUM_SRC-1:0]                in_src_en
);

  localparam int MAX_A   = (LAT_ALU > LAT_MUL) ? LAT_ALU : LAT_MUL;
  localparam int MAX_B   = (LAT_IDIV > LAT_LD) ? LAT_IDIV : LAT_LD;
  localparam int MAX_C   = (LAT_FLD > LAT_FOP) ? LAT_FLD : LAT_FOP;
  localparam int MAX_D   = (LAT_FDIV > LAT_CR) ? LAT_FDIV : LAT_CR;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CD  = (MAX_C > MAX_D) ? MAX_C : MAX_D;
  localparam int LAT_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = (LAT_MAX < 2) ? 1 : $clog2(LAT_MAX);

  function automatic logic [CNT_W-1:0] countdown(input logic [2:0] c);
    case (lat_class_e'(c))
      CLS_ALU:  return CNT_W'(LAT_ALU - 1);
      CLS_MUL:  return CNT_W'(LAT_MUL - 1);
      CLS_IDIV: return CNT_W'(LAT_IDIV - 1);
      CLS_LD:   return CNT_W'(LAT_LD - 1);
      CLS_FLD:  return CNT_W'(LAT_FLD - 1);
      CLS_FOP:  return CNT_W'(LAT_FOP - 1);
      CLS_FDIV: return CNT_W'(LAT_FDIV - 1);
      default:  return CNT_W'(LAT_CR - 1);
    endcase
  endfunction

  logic [1:0][NUM_REGS-1:0] busy_map;   // index 0 integer file, 1 floating-point file
  logic                     idiv_locked;
  logic                     fdiv_locked;
  logic [SLOTS-1:0]         solo_ok;
  logic                     pair_ok;
  logic [SLOTS-1:0]         fire;
  logic [SLOTS-1:0][CNT_W-1:0] slot_cd;
  logic                     idiv_start;
  logic                     fdiv_start;

  // Per-slot hazard check against tracked state
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    sb_slot_check #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .NUM_SRC  (NUM_SRC)
    ) u_solo (
      .busy_int   (busy_map[0]),
      .busy_fp    (busy_map[1]),
      .mdv_locked (idiv_locked),
      .fpu_locked (fdiv_locked),
      .cls        (in_class[s]),
      .dst        (in_dst[s]),
      .dst_fp     (in_dst_fp[s]),
      .dst_en     (in_dst_en[s]),
      .src        (in_src[s]),
      .src_fp     (in_src_fp[s]),
      .src_en     (in_src_en[s]),
      .ok         (solo_ok[s])
    );
    assign slot_cd[s] = countdown(in_class[s]);
  end

  // Same-cycle hazards between the older and younger slot
  sb_pair_check #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC)
  ) u_pair (
    .old_cls    (in_class[0]),
    .old_dst    (in_dst[0]),
    .old_dst_fp (in_dst_fp[0]),
    .old_dst_en (in_dst_en[0]),
    .yng_cls    (in_class[1]),
    .yng_dst    (in_dst[1]),
    .yng_dst_fp (in_dst_fp[1]),
    .yng_dst_en (in_dst_en[1]),
    .yng_src    (in_src[1]),
    .yng_src_fp (in_src_fp[1]),
    .yng_src_en (in_src_en[1]),
    .ok         (pair_ok)
  );

  assign in_ready[0] = solo_ok[0];
  assign in_ready[1] = solo_ok[1] && in_valid[0] && solo_ok[0] && pair_ok;
  assign fire        = in_valid & in_ready;

  // One countdown bank per register file
  for (genvar f = 0; f < 2; f++) begin : g_file
    logic [SLOTS-1:0] wr_en;
    for (genvar s = 0; s < SLOTS; s++) begin : g_wr
      assign wr_en[s] = fire[s] && in_dst_en[s] && (in_dst_fp[s] == 1'(f));
    end
    sb_cnt_bank #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W),
      .CNT_W    (CNT_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (in_dst),
      .wr_val (slot_cd),
      .busy   (busy_map[f])
    );
  end

  // Non-pipelined divider occupancy
  always_comb begin
    idiv_start = 1'b0;
    fdiv_start = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (fire[s] && in_class[s] == CLS_IDIV) idiv_start = 1'b1;
      if (fire[s] && in_class[s] == CLS_FDIV) fdiv_start = 1'b1;
    end
  end

  sb_unit_lock #(.CNT_W(CNT_W)) u_idiv_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (idiv_start),
    .start_val (CNT_W'(LAT_IDIV - 1)),
    .locked    (idiv_locked)
  );

  sb_unit_lock #(.CNT_W(CNT_W)) u_fdiv_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fdiv_start),
    .start_val (CNT_W'(LAT_FDIV - 1)),
    .locked    (fdiv_locked)
  );

endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [1:0]                         in_valid,
  input logic [1:0]                         in_ready,
  input logic [1:0][2:0]                    in_class,
  input logic [1:0][REG_W-1:0]              in_dst,
  input logic [1:0]                         in_dst_fp,
  input logic [1:0]                         in_dst_en,
  input logic [1:0][NUM_SRC-1:0][REG_W-1:0] in_src,
  input logic [1:0][NUM_SRC-1:0]            in_src_fp,
  input logic [1:0][NUM_SRC-1:0]            in_src_en
);

  logic fire0;
  logic idiv_fire;
  logic raw_pair;
  logic unit_pair;

  assign fire0     = in_valid[0] && in_ready[0];
  assign idiv_fire = (in_valid[0] && in_ready[0] && in_class[0] == CLS_IDIV) ||
                     (in_valid[1] && in_ready[1] && in_class[1] == CLS_IDIV);
  assign unit_pair = unit_of(lat_class_e'(in_class[0])) == unit_of(lat_class_e'(in_class[1])) &&
                     unit_of(lat_class_e'(in_class[0])) != UNIT_DUP;

  always_comb begin
    raw_pair = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (in_src_en[1][k] && in_dst_en[0] && in_src_fp[1][k] == in_dst_fp[0] &&
          in_src[1][k] == in_dst[0]) begin
        raw_pair = 1'b1;
      end
    end
  end

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready[1] |-> (in_valid[0] && in_ready[0])); // R9

  AST_PAIR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready[1] |-> !raw_pair); // R7

  AST_PAIR_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready[1] |-> !unit_pair); // R8

  AST_IDIV_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    idiv_fire |=> !(in_ready[0] && (in_class[0] == CLS_MUL || in_class[0] == CLS_IDIV))); // R6

  AST_FOP_SRC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire0 && in_dst_en[0] && in_class[0] == CLS_FOP) |=>
      !(in_ready[0] && in_src_en[0][0] && in_src[0][0] == $past(in_dst[0]) &&
        in_src_fp[0][0] == $past(in_dst_fp[0]))); // R2

  AST_FOP_DST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire0 && in_dst_en[0] && in_class[0] == CLS_FOP) |=>
      !(in_ready[0] && in_dst_en[0] && in_dst[0] == $past(in_dst[0]) &&
        in_dst_fp[0] == $past(in_dst_fp[0]))); // R5

endmodule

bind dual_issue_scoreboard sb_checker #(
  .REG_W   (REG_W),
  .NUM_SRC (NUM_SRC)
) u_sb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_class  (in_class),
  .in_dst    (in_dst),
  .in_dst_fp (in_dst_fp),
  .in_dst_en (in_dst_en),
  .in_src    (in_src),
  .in_src_fp (in_src_fp),
  .in_src_en (in_src_en)
);

// File: tb/dual_issue_scoreboard_bench.sv
`timescale 1ns/1ps
module dual_issue_scoreboard_bench;

  localparam real HALF = 2.5;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           v;
  logic [1:0]           rdy;
  logic [1:0][2:0]      cls;
  logic [1:0][4:0]      dst;
  logic [1:0]           dfp, den;
  logic [1:0][1:0][4:0] src;
  logic [1:0][1:0]      sfp, sen;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int icnt [32];
  int fcnt [32];
  int ilock, flock;

  always #(HALF) clk = ~clk;

  dual_issue_scoreboard u_dual_issue_scoreboard (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (v),
    .in_ready  (rdy),
    .in_class  (cls),
    .in_dst    (dst),
    .in_dst_fp (dfp),
    .in_dst_en (den),
    .in_src    (src),
    .in_src_fp (sfp),
    .in_src_en (sen)
  );

  // ---------------- reference model ----------------
  function automatic int lat(int c);
    case (c)
      0: return 1;  1: return 3;  2: return 33; 3: return 3;
      4: return 4;  5: return 5;  6: return 30; default: return 2;
    endcase
  endfunction

  function automatic int unitf(int c);
    if (c == 1 || c == 2) return 1;
    if (c == 3 || c == 4) return 2;
    if (c >= 5) return 3;
    return 0;
  endfunction

  function automatic bit busy(bit fp, int idx);
    return fp ? (fcnt[idx] > 0) : (icnt[idx] > 0);
  endfunction

  function automatic bit solo(int s);
    bit ok = 1;
    for (int k = 0; k < 2; k++)
      if (sen[s][k] && busy(sfp[s][k], int'(src[s][k]))) ok = 0;
    if (den[s] && busy(dfp[s], int'(dst[s]))) ok = 0;
    if (unitf(int'(cls[s])) == 1 && ilock > 0) ok = 0;
    if (unitf(int'(cls[s])) == 3 && flock > 0) ok = 0;
    return ok;
  endfunction

  function automatic bit pair_bad();
    bit b = 0;
    for (int k = 0; k < 2; k++)
      if (sen[1][k] && den[0] && sfp[1][k] == dfp[0] && src[1][k] == dst[0]) b = 1;
    if (den[0] && den[1] && dfp[0] == dfp[1] && dst[0] == dst[1]) b = 1;
    if (unitf(int'(cls[0])) == unitf(int'(cls[1])) && unitf(int'(cls[0])) != 0) b = 1;
    return b;
  endfunction

  // ---------------- stimulus helpers ----------------
  task automatic setslot(int s, bit vv, int c, int d, bit d_fp, bit d_en,
                         int a, bit a_fp, bit a_en, int b, bit b_fp, bit b_en);
    v[s] = vv;  cls[s] = 3'(c);
    dst[s] = 5'(d); dfp[s] = d_fp; den[s] = d_en;
    src[s][0] = 5'(a); sfp[s][0] = a_fp; sen[s][0] = a_en;
    src[s][1] = 5'(b); sfp[s][1] = b_fp; sen[s][1] = b_en;
  endtask

  task automatic idle();
    setslot(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setslot(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // Called just after a falling edge with inputs applied.
  task automatic step(string tag);
    bit [1:0] e;
    #1;
    e[0] = solo(0);
    e[1] = solo(1) && v[0] && e[0] && !pair_bad();
    for (int s = 0; s < 2; s++) begin
      total++;
      if (rdy[s] !== e[s]) begin
        bad++;
        $display("FAIL %s slot%0d ready actual=%0b expected=%0b at %0t", tag, s, rdy[s], e[s], $time);
      end
    end
    for (int r = 0; r < 32; r++) begin
      if (icnt[r] > 0) icnt[r]--;
      if (fcnt[r] > 0) fcnt[r]--;
    end
    if (ilock > 0) ilock--;
    if (flock > 0) flock--;
    for (int s = 0; s < 2; s++) begin
      if (v[s] && e[s]) begin
        if (den[s]) begin
          if (dfp[s]) fcnt[dst[s]] = lat(int'(cls[s])) - 1;
          else        icnt[dst[s]] = lat(int'(cls[s])) - 1;
        end
        if (cls[s] == 3'd2) ilock = lat(2) - 1;
        if (cls[s] == 3'd6) flock = lat(6) - 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic drain(int n);
    idle();
    for (int i = 0; i < n; i++) step("drain");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int r = 0; r < 32; r++) begin icnt[r] = 0; fcnt[r] = 0; end
    ilock = 0; flock = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything free after reset
    setslot(0, 1, 1, 1, 0, 1, 2, 0, 1, 3, 1, 1);
    setslot(1, 1, 5, 4, 1, 1, 6, 1, 1, 7, 0, 1);
    step("R1");
    drain(4);

    // R3 / R2: latency sweep, reader presented every cycle
    for (int c = 0; c < 8; c++) begin
      bit fpf = (c >= 4);
      idle();
      setslot(0, 1, c, 5, fpf, 1, 0, 0, 0, 0, 0, 0);
      step("R3");
      for (int i = 0; i < 36; i++) begin
        setslot(0, 1, 0, 0, 0, 0, 5, fpf, 1, 0, 0, 0);
        step("R2");
      end
      drain(34);
    end

    // R4: file separation
    idle();
    setslot(0, 1, 3, 3, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R4");
    setslot(0, 1, 0, 0, 0, 0, 3, 1, 1, 0, 0, 0);   // fp r3 free
    step("R4");
    setslot(0, 1, 0, 0, 0, 0, 3, 0, 1, 0, 0, 0);   // int r3 busy
    step("R4");
    drain(5);

    // R5: destination still busy
    setslot(0, 1, 6, 7, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R5");
    for (int i = 0; i < 32; i++) begin
      setslot(0, 1, 0, 7, 1, 1, 0, 0, 0, 0, 0, 0);
      step("R5");
    end
    drain(32);

    // R6: divider occupancy
    setslot(0, 1, 2, 9, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R6");
    for (int i = 0; i < 36; i++) begin
      setslot(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      setslot(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R6");
    end
    idle();
    setslot(0, 1, 6, 2, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R6");
    for (int i = 0; i < 32; i++) begin
      setslot(0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      setslot(1, 1, (i % 2 == 0) ? 5 : 7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R6");
    end
    drain(34);

    // R7: same-cycle register hazards
    setslot(0, 1, 0, 4, 0, 1, 0, 0, 0, 0, 0, 0);
    setslot(1, 1, 0, 0, 0, 0, 0, 0, 0, 4, 0, 1);
    step("R7");
    setslot(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setslot(1, 1, 0, 0, 0, 0, 4, 0, 1, 0, 0, 0);
    step("R7");
    setslot(0, 1, 0, 6, 0, 1, 0, 0, 0, 0, 0, 0);
    setslot(1, 1, 0, 6, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R7");
    setslot(0, 1, 0, 11, 0, 1, 0, 0, 0, 0, 0, 0);
    setslot(1, 1, 0, 11, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R4");
    setslot(0, 1, 0, 8, 1, 1, 0, 0, 0, 0, 0, 0);
    setslot(1, 1, 0, 0, 0, 0, 8, 0, 1, 0, 0, 0);
    step("R4");
    drain(3);

    // R8: single-unit pairing
    for (int p = 0; p < 6; p++) begin
      int c0, c1;
      case (p)
        0: begin c0 = 3; c1 = 3; end
        1: begin c0 = 3; c1 = 4; end
        2: begin c0 = 0; c1 = 0; end
        3: begin c0 = 1; c1 = 5; end
        4: begin c0 = 5; c1 = 7; end
        default: begin c0 = 1; c1 = 2; end
      endcase
      setslot(0, 1, c0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      setslot(1, 1, c1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R8");
      drain(1);
    end

    // R9: in-order issue
    setslot(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setslot(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9");
    idle();
    setslot(0, 1, 5, 12, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R9");
    setslot(0, 1, 0, 0, 0, 0, 12, 0, 1, 0, 0, 0);
    setslot(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9");
    drain(6);

    // R10: disabled fields ignored
    setslot(0, 1, 5, 13, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R10");
    setslot(0, 1, 0, 13, 0, 0, 13, 0, 0, 13, 0, 0);
    setslot(1, 1, 0, 14, 0, 0, 14, 0, 0, 13, 0, 0);
    step("R10");
    setslot(0, 1, 0, 14, 0, 0, 0, 0, 0, 0, 0, 0);
    setslot(1, 1, 0, 0, 0, 0, 14, 0, 1, 0, 0, 0);
    step("R10");
    drain(6);

    // R11: invalid slot records nothing
    setslot(0, 0, 2, 15, 0, 1, 0, 0, 0, 0, 0, 0);
    setslot(1, 0, 6, 16, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R11");
    setslot(0, 1, 1, 0, 0, 0, 15, 0, 1, 0, 0, 0);
    setslot(1, 1, 5, 0, 0, 0, 16, 1, 1, 0, 0, 0);
    step("R11");
    drain(4);

    // Mixed traffic on a narrow register window (R2)
    for (int i = 0; i < 4000; i++) begin
      for (int s = 0; s < 2; s++) begin
        int c = $urandom % 8;
        if ((c == 2 || c == 6) && ($urandom % 4 != 0)) c = 0;
        setslot(s, bit'($urandom % 4 != 0), c,
                $urandom % 8, bit'($urandom % 2), bit'($urandom % 3 != 0),
                $urandom % 8, bit'($urandom % 2), bit'($urandom % 2),
                $urandom % 8, bit'($urandom % 2), bit'($urandom % 2));
      end
      step("R2");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule